// File: doc/BRIEF.md
# Memory-Mapped Console Port

This block is a console peripheral that a processor reaches with word loads and stores. It has a receive side and a transmit side. The receive side takes bytes from an external byte stream and holds the latest one for software to collect. The transmit side passes bytes to an external sink, then stays busy for a number of cycles that software chooses. Each side has a ready flag and an interrupt enable. The block drives one level-sensitive interrupt line.

Software polls the ready flags, or enables interrupts and services the line. A load of the receive data register collects the byte and clears receive ready as a side effect. A store to the transmit data register while the transmitter is ready launches a character. If a byte arrives before the previous one has been collected, the new byte replaces it and a sticky overrun flag is set.

Top module: `mmio_console`

## Requirements
- R1: After reset the receive control register reads 0, the transmit control register reads 1 (ready, interrupts disabled), `irq_o` is 0 and `tx_vld_o` is 0.
- R2: Registers are decoded at BASE+0x0 (receive control), BASE+0x4 (receive data), BASE+0x8 (transmit control) and BASE+0xC (transmit data), with BASE = 0xffff0000. In control registers bit 0 is ready and bit 1 is interrupt enable. Bit 2 of receive control is overrun, and every other bit reads 0. Receive data returns the byte in bits 7:0 with zero above it. Transmit data and any other address read 0.
- R3: A cycle with `rx_vld_i` high stores `rx_byte_i`. From the next cycle, receive ready reads 1 and receive data returns that byte.
- R4: A load of receive data clears receive ready from the next cycle. If a byte arrives in the same cycle, ready stays 1 and the new byte is held, with no overrun.
- R5: A byte arriving while receive ready is 1 and no load of receive data is made in that cycle replaces the held byte and sets overrun. Overrun stays set until a load of receive control, which clears it. A new overrun in that same cycle keeps it set.
- R6: A store to transmit data while transmit ready is 1 pulses `tx_vld_o` for exactly one cycle, starting the next cycle, with `tx_byte_o` equal to store bits 7:0. Transmit ready then reads 0 for `tx_gap_i`+1 cycles, where `tx_gap_i` is sampled at the store.
- R7: A store to transmit data while transmit ready is 0 produces no pulse and does not change when ready returns.
- R8: Stores change only bit 1 of a control register. Ready and overrun bits, stores to receive data, and stores to unmapped addresses have no effect.
- R9: `irq_o` is 1 exactly when (receive ready AND receive enable) OR (transmit ready AND transmit enable).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel_i | input | 1 | Bus access in this cycle |
| bus_we_i | input | 1 | 1 = store, 0 = load |
| bus_addr_i | input | 32 | Byte address |
| bus_wdata_i | input | 32 | Store data |
| bus_rdata_o | output | 32 | Load data (combinational) |
| rx_vld_i | input | 1 | Incoming byte strobe |
| rx_byte_i | input | 8 | Incoming byte |
| tx_gap_i | input | 8 | Busy cycles after a launch, minus one |
| tx_vld_o | output | 1 | Outgoing byte strobe |
| tx_byte_o | output | 8 | Outgoing byte |
| irq_o | output | 1 | Interrupt request level |

## Verification
The receive path is tested with a single byte that is then collected, with two bytes and no load between them (overrun), and with an arrival in the same cycle as a load. These cases separate overwrite-with-overrun from the case where a collision loses no byte. The transmit path is tested with a gap of 3 and a gap of 0, with a store while busy, and with a store in the first cycle ready returns. This checks the busy length, the busy-store rule and back-to-back launches. Stores of all ones to every register, toggling of the enables, and the resulting interrupt line show that only the enable bits are writable.

// File: rtl/mmio_console_pkg.sv
package mmio_console_pkg;
  typedef enum logic [1:0] {
    SEL_RXCTL = 2'd0,
    SEL_RXDAT = 2'd1,
    SEL_TXCTL = 2'd2,
    SEL_TXDAT = 2'd3
  } reg_sel_e;

  localparam int BIT_RDY = 0;
  localparam int BIT_IE  = 1;
  localparam int BIT_OVR = 2;
endpackage

// File: rtl/mmio_console_rx.sv
module mmio_console_rx #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_vld_i,
  input  logic [DW-1:0] byte_i,
  input  logic          rd_data_i,
  input  logic          rd_ctl_i,
  input  logic          ie_we_i,
  input  logic          ie_d_i,
  output logic          rdy_o,
  output logic          ovr_o,
  output logic          ie_o,
  output logic [DW-1:0] dat_o,
  output logic          req_o
);
  logic          rdy_q, rdy_n;
  logic          ovr_q, ovr_n;
  logic          ie_q, ie_n;
  logic [DW-1:0] dat_q, dat_n;
  logic          ovr_set;

  always_comb begin
    ovr_set = byte_vld_i && rdy_q && !rd_data_i;
    rdy_n   = rdy_q;
    dat_n   = dat_q;
    ie_n    = ie_q;
    if (byte_vld_i) begin
      rdy_n = 1'b1;
      dat_n = byte_i;
    end else if (rd_data_i) begin
      rdy_n = 1'b0;
    end
    if (ovr_set)       ovr_n = 1'b1;
    else if (rd_ctl_i) ovr_n = 1'b0;
    else               ovr_n = ovr_q;
    if (ie_we_i) ie_n = ie_d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= 1'b0;
      ovr_q <= 1'b0;
      ie_q  <= 1'b0;
      dat_q <= '0;
    end else begin
      rdy_q <= rdy_n;
      ovr_q <= ovr_n;
      ie_q  <= ie_n;
      if (byte_vld_i) dat_q <= dat_n;
    end
  end

  assign rdy_o = rdy_q;
  assign ovr_o = ovr_q;
  assign ie_o  = ie_q;
  assign dat_o = dat_q;
  assign req_o = rdy_q & ie_q;

  p_arrive_sets_rdy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld_i |=> (rdy_q && dat_q == $past(byte_i)));
  p_load_clears_rdy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_i && !byte_vld_i) |=> !rdy_q);
  p_overrun_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld_i && rdy_q && !rd_data_i) |=> ovr_q);
  p_overrun_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !rd_ctl_i) |=> ovr_q);
endmodule

// File: rtl/mmio_console_tx.sv
module mmio_console_tx #(
  parameter int DW    = 8,
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_data_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [GAP_W-1:0] gap_i,
  input  logic             ie_we_i,
  input  logic             ie_d_i,
  output logic             rdy_o,
  output logic             ie_o,
  output logic             out_vld_o,
  output logic [DW-1:0]    out_byte_o,
  output logic             req_o
);
  logic             rdy_q, rdy_n;
  logic             ie_q, ie_n;
  logic [GAP_W-1:0] cnt_q, cnt_n;
  logic             vld_q;
  logic [DW-1:0]    byte_q;
  logic             launch;

  always_comb begin
    launch = wr_data_i && rdy_q;
    rdy_n  = rdy_q;
    cnt_n  = cnt_q;
    ie_n   = ie_q;
    if (launch) begin
      rdy_n = 1'b0;
      cnt_n = gap_i;
    end else if (!rdy_q) begin
      if (cnt_q == '0) rdy_n = 1'b1;
      else             cnt_n = cnt_q - 1'b1;
    end
    if (ie_we_i) ie_n = ie_d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q  <= 1'b1;
      ie_q   <= 1'b0;
      cnt_q  <= '0;
      vld_q  <= 1'b0;
      byte_q <= '0;
    end else begin
      rdy_q <= rdy_n;
      ie_q  <= ie_n;
      cnt_q <= cnt_n;
      vld_q <= launch;
      if (launch) byte_q <= wdata_i;
    end
  end

  assign rdy_o      = rdy_q;
  assign ie_o       = ie_q;
  assign out_vld_o  = vld_q;
  assign out_byte_o = byte_q;
  assign req_o      = rdy_q & ie_q;

  p_launch_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data_i && rdy_q) |=> (!rdy_q && out_vld_o && out_byte_o == $past(wdata_i)));
  p_busy_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy_q && cnt_q != '0) |=> !rdy_q);
  p_busy_store_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data_i && !rdy_q) |=> !out_vld_o);
endmodule

// File: rtl/mmio_console.sv
module mmio_console #(
  parameter int          AW        = 32,
  parameter int          DW        = 32,
  parameter int          CW        = 8,
  parameter int          GAP_W     = 8,
  parameter logic [31:0] BASE_ADDR = 32'hffff0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel_i,
  input  logic             bus_we_i,
  input  logic [AW-1:0]    bus_addr_i,
  input  logic [DW-1:0]    bus_wdata_i,
  output logic [DW-1:0]    bus_rdata_o,
  input  logic             rx_vld_i,
  input  logic [CW-1:0]    rx_byte_i,
  input  logic [GAP_W-1:0] tx_gap_i,
  output logic             tx_vld_o,
  output logic [CW-1:0]    tx_byte_o,
  output logic             irq_o
);
  import mmio_console_pkg::*;

  localparam logic [AW-1:0] BASE_W = AW'(BASE_ADDR);

  logic          hit;
  reg_sel_e      sel;
  logic          rd, wr;
  logic          rx_rdy, rx_ovr, rx_ie, rx_req;
  logic [CW-1:0] rx_dat;
  logic          tx_rdy, tx_ie, tx_req;

  assign hit = bus_sel_i && (bus_addr_i[AW-1:4] == BASE_W[AW-1:4]) &&
               (bus_addr_i[1:0] == 2'b00);
  assign sel = reg_sel_e'(bus_addr_i[3:2]);
  assign rd  = hit && !bus_we_i;
  assign wr  = hit && bus_we_i;

  mmio_console_rx #(.DW(CW)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_vld_i(rx_vld_i),
    .byte_i    (rx_byte_i),
    .rd_data_i (rd && sel == SEL_RXDAT),
    .rd_ctl_i  (rd && sel == SEL_RXCTL),
    .ie_we_i   (wr && sel == SEL_RXCTL),
    .ie_d_i    (bus_wdata_i[BIT_IE]),
    .rdy_o     (rx_rdy),
    .ovr_o     (rx_ovr),
    .ie_o      (rx_ie),
    .dat_o     (rx_dat),
    .req_o     (rx_req)
  );

  mmio_console_tx #(.DW(CW), .GAP_W(GAP_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_data_i (wr && sel == SEL_TXDAT),
    .wdata_i   (bus_wdata_i[CW-1:0]),
    .gap_i     (tx_gap_i),
    .ie_we_i   (wr && sel == SEL_TXCTL),
    .ie_d_i    (bus_wdata_i[BIT_IE]),
    .rdy_o     (tx_rdy),
    .ie_o      (tx_ie),
    .out_vld_o (tx_vld_o),
    .out_byte_o(tx_byte_o),
    .req_o     (tx_req)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (rd) begin
      case (sel)
        SEL_RXCTL: begin
          bus_rdata_o[BIT_RDY] = rx_rdy;
          bus_rdata_o[BIT_IE]  = rx_ie;
          bus_rdata_o[BIT_OVR] = rx_ovr;
        end
        SEL_RXDAT: bus_rdata_o[CW-1:0] = rx_dat;
        SEL_TXCTL: begin
          bus_rdata_o[BIT_RDY] = tx_rdy;
          bus_rdata_o[BIT_IE]  = tx_ie;
        end
        default: bus_rdata_o = '0;
      endcase
    end
  end

  assign irq_o = rx_req | tx_req;

  p_irq_needs_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (rx_rdy || tx_rdy));
  p_unmapped_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel_i && !bus_we_i && !hit) |-> (bus_rdata_o == '0));
endmodule

// File: tb/mmio_console_bench.sv
module mmio_console_bench;
  localparam logic [31:0] B = 32'hffff0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, we = 1'b0;
  logic [31:0] addr = '0, wdata = '0;
  logic [31:0] rdata;
  logic        rxv = 1'b0;
  logic [7:0]  rxb = '0;
  logic [7:0]  gap = '0;
  logic        txv;
  logic [7:0]  txb;
  logic        irq;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // behavioural reference state
  bit m_rrdy, m_rovr, m_rie, m_trdy, m_tie, m_txv;
  logic [7:0] m_rdat, m_txb;
  int m_cnt;

  always #10 clk = ~clk;

  mmio_console u_mmio_console (
    .clk(clk), .rst_n(rst_n), .bus_sel_i(sel), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .rx_vld_i(rxv), .rx_byte_i(rxb), .tx_gap_i(gap),
    .tx_vld_o(txv), .tx_byte_o(txb), .irq_o(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(logic [31:0] a);
    if (a == B)        return {29'd0, m_rovr, m_rie, m_rrdy};
    if (a == B + 4)    return {24'd0, m_rdat};
    if (a == B + 8)    return {30'd0, m_tie, m_trdy};
    return 32'd0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rrdy = 0; m_rovr = 0; m_rie = 0; m_rdat = 0;
      m_trdy = 1; m_tie = 0; m_cnt = 0; m_txv = 0; m_txb = 0;
    end else begin
      bit rd_d, rd_c, st_t, ovs, go;
      rd_d = sel && !we && addr == B + 4;
      rd_c = sel && !we && addr == B;
      st_t = sel && we && addr == B + 12;
      ovs  = rxv && m_rrdy && !rd_d;
      go   = st_t && m_trdy;
      if (rxv) begin m_rrdy = 1; m_rdat = rxb; end
      else if (rd_d) m_rrdy = 0;
      if (ovs) m_rovr = 1; else if (rd_c) m_rovr = 0;
      if (sel && we && addr == B) m_rie = wdata[1];
      if (go) begin m_trdy = 0; m_cnt = gap; end
      else if (!m_trdy) begin
        if (m_cnt == 0) m_trdy = 1; else m_cnt--;
      end
      m_txv = go;
      if (go) m_txb = wdata[7:0];
      if (sel && we && addr == B + 8) m_tie = wdata[1];
    end
  end

  // every-cycle comparison of registered outputs
  always @(negedge clk) if (rst_n && !done) begin
    check("R9 irq", {31'd0, irq}, {31'd0, (m_rrdy & m_rie) | (m_trdy & m_tie)});
    check("R6/R7 tx_vld", {31'd0, txv}, {31'd0, m_txv});
    if (m_txv) check("R6 tx_byte", {24'd0, txb}, {24'd0, m_txb});
  end

  task automatic cyc(bit s, bit w, logic [31:0] a, logic [31:0] d,
                     bit v, logic [7:0] b, string tag);
    @(negedge clk);
    sel = s; we = w; addr = a; wdata = d; rxv = v; rxb = b;
    #1;
    if (s && !w) check(tag, rdata, exp_rd(a));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, "");
  endtask

  task automatic rd(logic [31:0] a, string tag, logic [31:0] lit);
    cyc(1, 0, a, 0, 0, 0, tag);
    check({tag, " lit"}, rdata, lit);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    @(negedge clk); #1;
    check("R1 irq", {31'd0, irq}, 0);
    check("R1 tx_vld", {31'd0, txv}, 0);
    rd(B, "R1 rxctl", 32'h0);
    rd(B + 8, "R1 txctl", 32'h1);
    // R2 decode
    rd(B + 12, "R2 txdat", 32'h0);
    rd(B + 16, "R2 unmapped", 32'h0);
    rd(32'h0000_0004, "R2 low addr", 32'h0);
    rd(B + 5, "R2 misaligned", 32'h0);
    // R3 single byte
    cyc(0, 0, 0, 0, 1, 8'h5A, "");
    rd(B, "R3 rxctl", 32'h1);
    rd(B + 4, "R3 rxdat", 32'h5A);
    rd(B, "R4 cleared", 32'h0);
    // R5 overrun
    cyc(0, 0, 0, 0, 1, 8'h11, "");
    cyc(0, 0, 0, 0, 1, 8'h22, "");
    rd(B, "R5 ovr set", 32'h5);
    rd(B, "R5 ovr cleared", 32'h1);
    rd(B + 4, "R5 new byte", 32'h22);
    // R5 clear and set in one cycle
    cyc(0, 0, 0, 0, 1, 8'h33, "");
    cyc(1, 0, B, 0, 1, 8'h44, "R5 read with arrival");
    rd(B, "R5 set wins", 32'h5);
    cyc(1, 0, B + 4, 0, 0, 0, "R5 drain");
    rd(B, "R5 drained", 32'h0);
    // R4 read data while a byte arrives
    cyc(0, 0, 0, 0, 1, 8'h66, "");
    cyc(1, 0, B + 4, 0, 1, 8'h77, "R4 collide read");
    rd(B, "R4 collide rdy", 32'h1);
    rd(B + 4, "R4 collide byte", 32'h77);
    // R8 writes
    cyc(1, 1, B, 32'hFFFF_FFFF, 0, 0, "");
    rd(B, "R8 rx only ie", 32'h2);
    cyc(1, 1, B + 4, 32'hFFFF_FFAB, 0, 0, "");
    rd(B + 4, "R8 rxdat store ignored", 32'h77);
    cyc(1, 1, B + 16, 32'hFFFF_FFFF, 0, 0, "");
    rd(B + 8, "R8 unmapped store", 32'h1);
    cyc(1, 1, B + 8, 32'hFFFF_FFFE, 0, 0, "");
    rd(B + 8, "R8 tx ready kept", 32'h3);
    // R9 rx interrupt
    cyc(0, 0, 0, 0, 1, 8'h9C, "");
    idle(1);
    check("R9 irq both", {31'd0, irq}, 1);
    cyc(1, 1, B + 8, 0, 0, 0, "");
    cyc(1, 0, B + 4, 0, 0, 0, "R9 rx drain");
    idle(1);
    check("R9 irq off", {31'd0, irq}, 0);
    cyc(1, 1, B, 0, 0, 0, "");
    // R6 launch with gap 3, R7 busy store
    gap = 8'd3;
    cyc(1, 1, B + 12, 32'hABCD_0041, 0, 0, "");
    rd(B + 8, "R6 busy", 32'h0);
    gap = 8'd0;
    cyc(1, 1, B + 12, 32'h0000_0042, 0, 0, "");
    rd(B + 8, "R7 still busy", 32'h0);
    rd(B + 8, "R6 last busy", 32'h0);
    rd(B + 8, "R6 ready again", 32'h1);
    // R6 gap 0 back-to-back
    cyc(1, 1, B + 12, 32'h0000_0050, 0, 0, "");
    rd(B + 8, "R6 gap0 busy", 32'h0);
    cyc(1, 1, B + 12, 32'h0000_0051, 0, 0, "");
    idle(1);
    cyc(1, 1, B + 12, 32'h0000_0052, 0, 0, "");
    idle(2);
    // R9 tx interrupt
    cyc(1, 1, B + 8, 32'h2, 0, 0, "");
    idle(1);
    check("R9 tx irq", {31'd0, irq}, 1);
    gap = 8'd2;
    cyc(1, 1, B + 12, 32'h0000_0060, 0, 0, "");
    idle(1);
    check("R9 tx irq busy", {31'd0, irq}, 0);
    idle(4);
    check("R9 tx irq back", {31'd0, irq}, 1);
    idle(2);
    finish_run();
  end
endmodule